// File: doc/BRIEF.md
# Sixteen-Node Optical-Transpose Hypercube Permutation Engine

This block is a cycle-level model of a small two-level network: sixteen nodes in four groups of four. Inside a group, nodes form a two-dimensional hypercube joined by electronic links. Between groups, an optical transpose link carries node `(g,p)` to node `(p,g)`. Each node holds a primary register A and a scratch register B. A sequencer runs one of four fixed data-rearrangement programs on these registers and applies one network step per clock cycle.

A step is one of four kinds. It can exchange the B registers of every pair of nodes whose indices differ only in a chosen bit. It can exchange both registers across a chosen bit. It can swap A with B inside every node where index bit `i` differs from bit `i+1`. Or it can make an optical transpose move of both registers. The perfect shuffle interleaves B-register exchanges and in-node A/B swaps around two optical moves, and the unshuffle replays that schedule backwards. Vector reversal is a local reversal, an optical move, a second local reversal and a second optical move. Transpose is one optical move.

Software-side logic fills the A registers through a load port while the engine is idle. It pulses `start` with a program code, waits for `done` and reads the permuted A registers back through a combinational read port. Two counters report how many electronic and optical moves the last program used.

Top module: `otis_perm_engine`

## Requirements
- R1: After reset, `busy` and `done` are low, both move counters read 0, and every A register reads 0.
- R2: While `busy` is low, `ld_en` high at a clock edge writes `ld_data` into the A register at node `ld_idx`. `rd_data` shows the A register at node `rd_idx` combinationally. Node index bits [3:2] are the group and bits [1:0] are the local position.
- R3: When `start` is sampled high while idle, `busy` rises at that edge and the program runs for L cycles: L=1 for transpose, 11 for shuffle and unshuffle, 6 for vector reversal. `done` is high for exactly the one cycle after the final step, and `busy` is low in that cycle.
- R4: Program code 0 (transpose) leaves at node `{i[1:0],i[3:2]}` the value that was at node `{i[3:2],i[1:0]}`. It uses 1 optical and 0 electronic moves.
- R5: Program code 1 (perfect shuffle) moves the value at source index s to index `{s[2:0],s[3]}`, a rotate left by one. It uses 4 electronic and 2 optical moves. A step that exchanges only B registers leaves all A registers unchanged.
- R6: Program code 2 (unshuffle) moves the value at source index s to `{s[0],s[3:1]}`, a rotate right by one. It uses 4 electronic and 2 optical moves.
- R7: Program code 3 (vector reversal) moves the value at source index s to the bitwise complement `~s`. It uses 4 electronic and 2 optical moves.
- R8: While `busy` is high, load requests and further `start` pulses, including ones with a different program code, have no effect on the result or on the run length.
- R9: Accepting `start` clears both move counters. Each optical step adds 1 to the optical counter. The counters hold their values while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the selected program when idle |
| prog_sel | input | 2 | Program code: 0 transpose, 1 shuffle, 2 unshuffle, 3 vector reversal |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse after the final step |
| ld_en | input | 1 | Write enable for an A register (idle only) |
| ld_idx | input | 4 | Node index for the write |
| ld_data | input | 8 | Value to write |
| rd_idx | input | 4 | Node index for the read |
| rd_data | output | 8 | A register of node `rd_idx` |
| elec_moves | output | 4 | Electronic moves used by the last program |
| opt_moves | output | 4 | Optical moves used by the last program |

## Verification
The assertions assume that `start` and `ld_en` are synchronous levels that may arrive at any time, including during a run, and that every 2-bit program code is legal. They also assume the A registers change during a run only by network steps, so no load slips in under `busy`. The stimulus drives inputs only at falling edges. It fills the nodes with identity patterns and with seeded random bytes, and it picks programs at random. In one run it deliberately fires a load and a second `start` mid-program, to show that both are dropped while the counters and the A contents follow the schedule alone.

// File: rtl/otis_pkg.sv
package otis_pkg;

  localparam int OP_BIT_W = 4;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_XB   = 3'd1,   // exchange B across one index bit
    OP_XAB  = 3'd2,   // exchange A and B across one index bit
    OP_LOC  = 3'd3,   // in-node A/B swap where bit i != bit i+1
    OP_OTIS = 3'd4    // optical transpose move of both registers
  } op_kind_e;

  typedef enum logic [1:0] {
    PRG_TRANS  = 2'd0,
    PRG_SHUF   = 2'd1,
    PRG_UNSHUF = 2'd2,
    PRG_VREV   = 2'd3
  } prog_e;

  typedef struct packed {
    op_kind_e              kind;
    logic [OP_BIT_W-1:0]   sel;
  } step_op_t;

  function automatic step_op_t mk_op(op_kind_e k, int b);
    step_op_t o;
    o.kind = k;
    o.sel  = OP_BIT_W'(b);
    return o;
  endfunction

  function automatic int prog_len(prog_e p, int d);
    int n;
    case (p)
      PRG_TRANS:           n = 1;
      PRG_SHUF, PRG_UNSHUF: n = 8 * d - 5;
      default:             n = 2 * d + 2;
    endcase
    return n;
  endfunction

  // Forward shuffle schedule: seed swap, first loop, optical move,
  // second loop, optical move, B exchange on bit 0, closing swap.
  function automatic step_op_t shuffle_op(int k, int d);
    int l1, l2, j;
    step_op_t o;
    l1 = 2 * d - 3;
    l2 = 2 * d - 2;
    o  = mk_op(OP_LOC, 0);
    if (k == 0) begin
      o = mk_op(OP_LOC, 0);
    end else if (k <= 2 * l1) begin
      j = k - 1;
      o = mk_op((j % 2 == 0) ? OP_XB : OP_LOC, 1 + j / 2);
    end else if (k == 2 * l1 + 1) begin
      o = mk_op(OP_OTIS, 0);
    end else if (k <= 2 * l1 + 1 + 2 * l2) begin
      j = k - 2 * l1 - 2;
      o = mk_op((j % 2 == 0) ? OP_XB : OP_LOC, j / 2);
    end else if (k == 2 * l1 + 2 * l2 + 2) begin
      o = mk_op(OP_OTIS, 0);
    end else if (k == 2 * l1 + 2 * l2 + 3) begin
      o = mk_op(OP_XB, 0);
    end else begin
      o = mk_op(OP_LOC, 0);
    end
    return o;
  endfunction

  function automatic step_op_t vrev_op(int k, int d);
    step_op_t o;
    if (k < d)              o = mk_op(OP_XAB, k);
    else if (k == d)        o = mk_op(OP_OTIS, 0);
    else if (k < 2 * d + 1) o = mk_op(OP_XAB, k - d - 1);
    else                    o = mk_op(OP_OTIS, 0);
    return o;
  endfunction

  function automatic step_op_t prog_op(prog_e p, int k, int d);
    step_op_t o;
    case (p)
      PRG_TRANS:  o = mk_op(OP_OTIS, 0);
      PRG_SHUF:   o = shuffle_op(k, d);
      PRG_UNSHUF: o = shuffle_op(prog_len(p, d) - 1 - k, d);
      default:    o = vrev_op(k, d);
    endcase
    return o;
  endfunction

  // Node that feeds node idx on an optical move: group and local swapped.
  function automatic int otis_peer(int idx, int d);
    int lo, hi;
    lo = idx & ((1 << d) - 1);
    hi = (idx >> d) & ((1 << d) - 1);
    return (lo << d) | hi;
  endfunction

  function automatic logic loc_cond(int idx, int b);
    return (((idx >> b) ^ (idx >> (b + 1))) & 1) == 1;
  endfunction

endpackage

// File: rtl/otis_seq.sv
module otis_seq
  import otis_pkg::*;
#(
  parameter int D      = 2,
  parameter int STEP_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  prog_e    prog_sel,
  output logic     busy,
  output logic     done,
  output logic     launch,
  output step_op_t run_op
);

  logic                busy_q;
  logic                done_q;
  logic                last_step;
  prog_e               prog_q;
  logic [STEP_W-1:0]   step_q;

  assign launch    = start && !busy_q;
  assign last_step = busy_q && (int'(step_q) == prog_len(prog_q, D) - 1);
  assign run_op    = busy_q ? prog_op(prog_q, int'(step_q), D) : mk_op(OP_NOP, 0);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      prog_q <= PRG_TRANS;
    end else begin
      done_q <= last_step;
      if (launch) begin
        busy_q <= 1'b1;
        step_q <= '0;
        prog_q <= prog_sel;
      end else if (busy_q) begin
        if (last_step) busy_q <= 1'b0;
        step_q <= step_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/otis_node_array.sv
module otis_node_array
  import otis_pkg::*;
#(
  parameter int D = 2,
  parameter int W = 8,
  localparam int IW = 2 * D,
  localparam int N  = 1 << IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [IW-1:0]       ld_idx,
  input  logic [W-1:0]        ld_data,
  input  logic                clr_b,
  input  step_op_t            op,
  output logic [N-1:0][W-1:0] a_regs
);

  logic [N-1:0][W-1:0] a_q, b_q, a_n, b_n;

  always_comb begin
    logic [IW-1:0] me;
    logic [IW-1:0] pr;
    a_n = a_q;
    b_n = b_q;
    me  = '0;
    pr  = '0;
    for (int n = 0; n < N; n++) begin
      me = IW'(n);
      case (op.kind)
        OP_XB: begin
          pr = me ^ (IW'(1) << op.sel);
          b_n[me] = b_q[pr];
        end
        OP_XAB: begin
          pr = me ^ (IW'(1) << op.sel);
          a_n[me] = a_q[pr];
          b_n[me] = b_q[pr];
        end
        OP_LOC: begin
          if (loc_cond(n, int'(op.sel))) begin
            a_n[me] = b_q[me];
            b_n[me] = a_q[me];
          end
        end
        OP_OTIS: begin
          pr = IW'(otis_peer(n, D));
          a_n[me] = a_q[pr];
          b_n[me] = b_q[pr];
        end
        default: ;
      endcase
    end
    if (clr_b) b_n = '0;
    if (ld_en) a_n[ld_idx] = ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_n;
      b_q <= b_n;
    end
  end

  assign a_regs = a_q;

endmodule

// File: rtl/otis_move_count.sv
module otis_move_count
  import otis_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  op_kind_e         kind,
  output logic             elec_ev,
  output logic             opt_ev,
  output logic [CNT_W-1:0] elec_cnt,
  output logic [CNT_W-1:0] opt_cnt
);

  assign elec_ev = (kind == OP_XB) || (kind == OP_XAB);
  assign opt_ev  = (kind == OP_OTIS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      elec_cnt <= '0;
      opt_cnt  <= '0;
    end else begin
      if (elec_ev) elec_cnt <= elec_cnt + 1'b1;
      if (opt_ev)  opt_cnt  <= opt_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/otis_perm_engine.sv
module otis_perm_engine
  import otis_pkg::*;
#(
  parameter int D     = 2,
  parameter int W     = 8,
  parameter int CNT_W = 4,
  localparam int IW   = 2 * D,
  localparam int N    = 1 << IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       prog_sel,
  output logic             busy,
  output logic             done,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [W-1:0]     ld_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] elec_moves,
  output logic [CNT_W-1:0] opt_moves
);

  localparam int STEP_W = $clog2(8 * D);

  logic                launch;
  logic                ld_ok;
  logic                elec_ev, opt_ev;
  step_op_t            run_op;
  logic [N-1:0][W-1:0] a_regs;

  otis_seq #(.D(D), .STEP_W(STEP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .prog_sel (prog_e'(prog_sel)),
    .busy     (busy),
    .done     (done),
    .launch   (launch),
    .run_op   (run_op)
  );

  assign ld_ok = ld_en && !busy;

  otis_node_array #(.D(D), .W(W)) u_nodes (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_ok),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .clr_b   (launch),
    .op      (run_op),
    .a_regs  (a_regs)
  );

  otis_move_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .kind     (run_op.kind),
    .elec_ev  (elec_ev),
    .opt_ev   (opt_ev),
    .elec_cnt (elec_moves),
    .opt_cnt  (opt_moves)
  );

  assign rd_data = a_regs[rd_idx];

endmodule

// File: rtl/otis_perm_engine_chk.sv
module otis_perm_engine_chk
  import otis_pkg::*;
#(
  parameter int D     = 2,
  parameter int W     = 8,
  parameter int CNT_W = 4,
  localparam int N    = 1 << (2 * D)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [2:0]       op_kind,
  input logic [N*W-1:0]   a_flat,
  input logic [CNT_W-1:0] elec_moves,
  input logic [CNT_W-1:0] opt_moves
);

  // R3: done lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done marks the end of the run
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: counters start from zero on every accepted launch
  p_launch_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (elec_moves == '0 && opt_moves == '0));

  // R9: counters hold while idle
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(elec_moves) && $stable(opt_moves)));

  // R9: one optical step adds exactly one
  p_opt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_kind == OP_OTIS) |=> opt_moves == CNT_W'($past(opt_moves) + 1'b1));

  // R5, R8: a B-only exchange leaves every A register untouched, loads included
  p_bswap_keeps_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_kind == OP_XB) |=> $stable(a_flat));

  // R3: an idle start always launches
  p_start_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

endmodule

bind otis_perm_engine otis_perm_engine_chk #(.D(D), .W(W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .op_kind    (run_op.kind),
  .a_flat     (a_regs),
  .elec_moves (elec_moves),
  .opt_moves  (opt_moves)
);

// File: tb/otis_perm_engine_bench.sv
module otis_perm_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] prog_sel = 2'd0;
  logic       busy, done;
  logic       ld_en = 1'b0;
  logic [3:0] ld_idx = 4'd0;
  logic [7:0] ld_data = 8'd0;
  logic [3:0] rd_idx = 4'd0;
  logic [7:0] rd_data;
  logic [3:0] elec_moves, opt_moves;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] img [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  otis_perm_engine u_otis_perm_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_sel(prog_sel),
    .busy(busy), .done(done), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .elec_moves(elec_moves), .opt_moves(opt_moves)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Source node whose value must land at node i.
  function automatic logic [3:0] src_of(input logic [1:0] p, input logic [3:0] i);
    case (p)
      2'd0:    return {i[1:0], i[3:2]};
      2'd1:    return {i[0], i[3:1]};
      2'd2:    return {i[2:0], i[3]};
      default: return ~i;
    endcase
  endfunction

  function automatic int run_len(input logic [1:0] p);
    return (p == 2'd0) ? 1 : (p == 2'd3) ? 6 : 11;
  endfunction

  function automatic string req_of(input logic [1:0] p);
    case (p)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic load_all(input logic rnd);
    for (int i = 0; i < 16; i++) begin
      img[i] = rnd ? 8'($urandom) : 8'(i);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rd_data == img[i], "R2", int'(rd_data), int'(img[i]));
    end
  endtask

  task automatic run_prog(input logic [1:0] p, input logic inject);
    logic [7:0] nxt [16];
    int n;
    @(negedge clk);
    prog_sel = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3", int'(busy), 1);
    chk(elec_moves == 4'd0 && opt_moves == 4'd0, "R9", int'(elec_moves) + int'(opt_moves), 0);
    n = 0;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
      if (inject && n == 2) begin
        ld_en = 1'b1; ld_idx = 4'd5; ld_data = 8'hA5;
        start = 1'b1; prog_sel = ~p;
      end else begin
        ld_en = 1'b0; start = 1'b0;
      end
    end
    ld_en = 1'b0; start = 1'b0;
    chk(n == run_len(p), inject ? "R8" : "R3", n, run_len(p));
    chk(busy == 1'b0, "R3", int'(busy), 0);
    chk(elec_moves == ((p == 2'd0) ? 4'd0 : 4'd4), req_of(p), int'(elec_moves),
        (p == 2'd0) ? 0 : 4);
    chk(opt_moves == ((p == 2'd0) ? 4'd1 : 4'd2), req_of(p), int'(opt_moves),
        (p == 2'd0) ? 1 : 2);
    for (int i = 0; i < 16; i++) begin
      nxt[i] = img[src_of(p, 4'(i))];
      rd_idx = 4'(i);
      #1;
      chk(rd_data == nxt[i], inject ? "R8" : req_of(p), int'(rd_data), int'(nxt[i]));
    end
    for (int i = 0; i < 16; i++) img[i] = nxt[i];
    @(negedge clk);
    chk(done == 1'b0, "R3", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(elec_moves == ((p == 2'd0) ? 4'd0 : 4'd4), "R9", int'(elec_moves),
        (p == 2'd0) ? 0 : 4);
    chk(opt_moves == ((p == 2'd0) ? 4'd1 : 4'd2), "R9", int'(opt_moves),
        (p == 2'd0) ? 1 : 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(elec_moves == 4'd0 && opt_moves == 4'd0, "R1", int'(elec_moves) + int'(opt_moves), 0);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rd_data == 8'd0, "R1", int'(rd_data), 0);
    end
    // directed: identity pattern through each program
    for (int p = 0; p < 4; p++) begin
      load_all(1'b0);
      run_prog(2'(p), 1'b0);
    end
    // R8: mid-run load and restart attempts
    load_all(1'b1);
    run_prog(2'd1, 1'b1);
    load_all(1'b1);
    run_prog(2'd3, 1'b1);
    // chained programs on one image: shuffle then unshuffle restores it
    load_all(1'b1);
    run_prog(2'd1, 1'b0);
    run_prog(2'd2, 1'b0);
    // random programs on random data
    for (int k = 0; k < 10; k++) begin
      if (k % 3 == 0) load_all(1'b1);
      run_prog(2'($urandom_range(0, 3)), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule